// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the memory side of a serial flash that answers a single command: the byte read. A host selects it by pulling `cs_n` low and clocks it in SPI mode 0. The host then shifts in an instruction byte and a 24-bit start address. The block answers by streaming bytes from its internal byte-wide array, most significant bit first, for as long as the host keeps clocking.

After every byte the address steps to the next location. At the top of the array it wraps to zero, so the whole array can be read again and again in one transaction. Raising `cs_n` ends the transaction at any bit. A `busy` input stands for an erase, program or write cycle that is running. A read that arrives while `busy` is high is dropped, and the running cycle is left untouched.

The SPI pins are oversampled by the block's own clock. The array is loaded from the chip side through a simple byte write port. Its depth is set by `ADDR_W`.

Top module: `sflash_read_resp`

## Requirements
- R1: After reset, `sdo_oe` is 0 and `sdo` is not driven.
- R2: `sdo_oe` stays 0 whenever `cs_n` is high, and through the 8 instruction bits and 24 address bits of every transaction.
- R3: Only the instruction byte 8'h03 starts a read. With any other value, `sdo_oe` stays 0 until `cs_n` rises.
- R4: The 24 address bits arrive MSB first, sampled on rising `sck`. Only the low `ADDR_W` bits select the first byte, and the bits above them are ignored.
- R5: Data leaves MSB first. Each bit changes only after a falling `sck` edge. Bit 7 of the first byte is valid before the 33rd rising edge.
- R6: After each full byte has been sent, the next byte comes from the following address.
- R7: After the byte at address 2**ADDR_W-1, the next byte comes from address 0, with no gap in the bit stream.
- R8: Raising `cs_n` at any bit position drops `sdo_oe` in the same clock cycle. The next transaction starts from a fresh instruction byte.
- R9: `busy` is sampled when the 8th instruction bit is taken. If it is high, the read is rejected and `sdo_oe` stays 0 for the rest of the transaction.
- R10: A byte written through the fill port (`fill_we`, `fill_addr`, `fill_data`) is the byte later returned for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| sdi | input | 1 | Serial data from the host |
| busy | input | 1 | High while an erase, program or write cycle runs |
| fill_we | input | 1 | Array write strobe |
| fill_addr | input | ADDR_W | Array write address |
| fill_data | input | 8 | Array write data |
| sdo | output | 1 | Serial data to the host, high impedance when not driven |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
Two events can land in the same clock cycle. One is the byte-boundary reload, which fetches the next byte and steps the address, possibly wrapping it to zero. The other is a chip-select abort.

The bench provokes this by raising `cs_n` a few bits into a fresh byte, just after a reload, and by running a read across the top of the array. Every sampled bit is judged against a behavioural model of the array. The output enable is then checked in the very cycle the select rises. A follow-up read confirms that no address or shift state leaked out of the aborted transaction.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int         CMD_BITS  = 8;
  localparam int         ADR_BITS  = 24;
  localparam int         CNT_W     = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rd_state_e;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RST_VAL;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_store.sv
module sfr_store #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/sfr_read_seq.sv
module sfr_read_seq
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mosi_s,
  input  logic              busy,
  input  logic [7:0]        rdata,
  output rd_state_e         state_q,
  output logic [CNT_W-1:0]  bit_cnt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              drive_q,
  output logic              sdo_q,
  output logic              byte_load
);
  localparam int SR_W = ADR_BITS - 1;

  rd_state_e          state_n;
  logic [CNT_W-1:0]   bit_cnt_n;
  logic [SR_W-1:0]    in_sr_q, in_sr_n;
  logic [ADDR_W-1:0]  addr_n;
  logic [6:0]         out_sr_q, out_sr_n;
  logic [2:0]         bit_idx_q, bit_idx_n;
  logic               sdo_n, drive_n;
  logic [ADR_BITS-1:0] rx_word;
  logic               rx_unused_parity;

  assign rx_word          = {in_sr_q, mosi_s};
  assign rx_unused_parity = ^rx_word;
  assign byte_load        = cs_act && (state_q == ST_DATA) && fall_evt && (bit_idx_q == 3'd0);

  always_comb begin
    state_n   = state_q;
    bit_cnt_n = bit_cnt_q;
    in_sr_n   = in_sr_q;
    addr_n    = addr_q;
    out_sr_n  = out_sr_q;
    bit_idx_n = bit_idx_q;
    sdo_n     = sdo_q;
    drive_n   = drive_q;
    if (!cs_act) begin
      state_n   = ST_IDLE;
      drive_n   = 1'b0;
      bit_cnt_n = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n   = ST_CMD;
          bit_cnt_n = '0;
        end
        ST_CMD: begin
          if (rise_evt) begin
            in_sr_n   = {in_sr_q[SR_W-2:0], mosi_s};
            bit_cnt_n = bit_cnt_q + CNT_W'(1);
            if (bit_cnt_q == CNT_W'(CMD_BITS - 1)) begin
              bit_cnt_n = '0;
              if ((rx_word[7:0] == RD_OPCODE) && !busy) state_n = ST_ADDR;
              else                                       state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR: begin
          if (rise_evt) begin
            in_sr_n   = {in_sr_q[SR_W-2:0], mosi_s};
            bit_cnt_n = bit_cnt_q + CNT_W'(1);
            if (bit_cnt_q == CNT_W'(ADR_BITS - 1)) begin
              addr_n    = rx_word[ADDR_W-1:0];
              bit_idx_n = 3'd0;
              state_n   = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (fall_evt) begin
            drive_n   = 1'b1;
            bit_idx_n = bit_idx_q + 3'd1;
            if (bit_idx_q == 3'd0) begin
              sdo_n    = rdata[7];
              out_sr_n = rdata[6:0];
              addr_n   = addr_q + ADDR_W'(1);
            end else begin
              sdo_n    = out_sr_q[6];
              out_sr_n = {out_sr_q[5:0], 1'b0};
            end
          end
        end
        ST_SKIP: begin
          drive_n = 1'b0;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_sr_q   <= '0;
      addr_q    <= '0;
      out_sr_q  <= '0;
      bit_idx_q <= '0;
      sdo_q     <= 1'b0;
      drive_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      bit_cnt_q <= bit_cnt_n;
      drive_q   <= drive_n;
      if (rise_evt || !cs_act) in_sr_q <= in_sr_n;
      if (rise_evt || fall_evt) begin
        addr_q    <= addr_n;
        bit_idx_q <= bit_idx_n;
      end
      if (fall_evt) begin
        out_sr_q <= out_sr_n;
        sdo_q    <= sdo_n;
      end
    end
  end
endmodule

// File: rtl/sflash_read_resp.sv
module sflash_read_resp
  import sfr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              busy,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [2:0]         pins_s;
  logic               cs_act, sck_s, mosi_s, sck_d_q;
  logic               rise_evt, fall_evt;
  rd_state_e          state_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               drive_q, sdo_q, byte_load;
  logic [7:0]         rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sfr_pin_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({cs_n, sck, sdi}),
    .q_o   (pins_s)
  );
  assign cs_act = ~pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sck_d_q <= 1'b0;
    else             sck_d_q <= sck_s;
  end
  assign rise_evt = sck_s & ~sck_d_q;
  assign fall_evt = ~sck_s & sck_d_q;

  sfr_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .we_i    (fill_we),
    .waddr_i (fill_addr),
    .wdata_i (fill_data),
    .re_i    (1'b1),
    .raddr_i (addr_q),
    .rdata_o (rdata)
  );

  sfr_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_act    (cs_act),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mosi_s    (mosi_s),
    .busy      (busy),
    .rdata     (rdata),
    .state_q   (state_q),
    .bit_cnt_q (bit_cnt_q),
    .addr_q    (addr_q),
    .drive_q   (drive_q),
    .sdo_q     (sdo_q),
    .byte_load (byte_load)
  );

  assign sdo_oe = drive_q & ~cs_n;
  assign sdo    = sdo_oe ? sdo_q : 1'bz;
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              busy,
  input rd_state_e         state_q,
  input logic [CNT_W-1:0]  bit_cnt_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              drive_q,
  input logic              sdo_q,
  input logic              byte_load
);
  assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |=> !drive_q);

  assert_quiet_in_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_IDLE, ST_CMD, ST_ADDR, ST_SKIP}) |-> !drive_q);

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && state_q == ST_CMD && rise_evt && bit_cnt_q == CNT_W'(CMD_BITS - 1) && busy)
      |=> state_q == ST_SKIP);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_addr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && addr_q == {ADDR_W{1'b1}}) |=> addr_q == '0);

  assert_bit_holds_between_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !fall_evt) |=> $stable(sdo_q));
endmodule

bind sflash_read_resp sfr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_act    (cs_act),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt),
  .busy      (busy),
  .state_q   (state_q),
  .bit_cnt_q (bit_cnt_q),
  .addr_q    (addr_q),
  .drive_q   (drive_q),
  .sdo_q     (sdo_q),
  .byte_load (byte_load)
);

// File: tb/sflash_read_resp_tb.sv
`timescale 1ns/100ps
module sflash_read_resp_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 5;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, sck, sdi, busy, fill_we;
  logic [AW-1:0] fill_addr;
  logic [7:0]    fill_data;
  wire           sdo;
  wire           sdo_oe;

  int    nchk = 0;
  int    nerr = 0;
  bit    exp_quiet = 1'b0;
  string quiet_req = "R2";
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  sflash_read_resp #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .busy(busy),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) ^ (i >> 5) ^ 8'h5A);
  endfunction

  // Per-clock model check of the output enable during quiet phases
  always @(negedge clk) begin
    if (rst_n === 1'b1 && exp_quiet)
      check(sdo_oe === 1'b0, quiet_req, "output enabled in quiet phase", int'(sdo_oe), 0);
  end

  task automatic xfer_bit(input logic b, output logic s, output logic oe);
    sdi = b;
    repeat (H - 1) tick();
    @(negedge clk);
    s  = sdo;
    oe = sdo_oe;
    tick();
    sck = 1'b1;
    repeat (H) tick();
    sck = 1'b0;
  endtask

  task automatic run_read(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                          input bit bsy, input int abort_bits, input string tag);
    bit   accept;
    int   a_eff;
    logic s, oe;
    accept = (op == 8'h03) && !bsy;
    a_eff  = int'(a) & (DEPTH - 1);
    busy   = bsy;
    quiet_req = accept ? "R2" : tag;
    exp_quiet = 1'b1;
    cs_n = 1'b0;
    repeat (4) tick();
    for (int i = 7; i >= 0; i--) xfer_bit(op[i], s, oe);
    for (int i = 23; i >= 0; i--) xfer_bit(a[i], s, oe);
    if (accept) exp_quiet = 1'b0;
    for (int k = 0; k < nbytes + ((abort_bits > 0) ? 1 : 0); k++) begin
      for (int b = 7; b >= 0; b--) begin
        if (k == nbytes && (7 - b) >= abort_bits) break;
        xfer_bit(1'b0, s, oe);
        if (accept) begin
          int    idx;
          logic  eb;
          string req;
          idx = (a_eff + k) % DEPTH;
          eb  = ref_mem[idx][b];
          if (tag != "")                    req = tag;
          else if (k == 0 && b == 7)        req = "R5";
          else if (k == 0)                  req = "R4";
          else if (idx < a_eff)             req = "R7";
          else                              req = "R6";
          check(oe === 1'b1 && s === eb, req, "data bit", int'({oe, s}), int'({1'b1, eb}));
        end else begin
          check(oe === 1'b0, tag, "rejected read drives output", int'(oe), 0);
        end
      end
    end
    if (abort_bits > 0 && accept) begin
      repeat (4) tick();
      check(sdo_oe === 1'b1, "R8", "driving before abort", int'(sdo_oe), 1);
      cs_n = 1'b1;
      exp_quiet = 1'b1;
      quiet_req = "R8";
      @(negedge clk);
      check(sdo_oe === 1'b0, "R8", "enable after abort", int'(sdo_oe), 0);
    end
    tick();
    cs_n = 1'b1;
    exp_quiet = 1'b1;
    quiet_req = "R2";
    busy = 1'b0;
    repeat (8) tick();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; busy = 1'b0;
    fill_we = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1: nothing driven after reset
    check(sdo_oe === 1'b0, "R1", "enable after reset", int'(sdo_oe), 0);
    exp_quiet = 1'b1;

    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = pat(i);
      fill_we = 1'b1; fill_addr = AW'(i); fill_data = ref_mem[i];
      tick();
    end
    // R10: overwrite one location, then read it back
    ref_mem[256] = 8'hC3;
    fill_addr = AW'(256); fill_data = 8'hC3;
    tick();
    fill_we = 1'b0;
    tick();

    run_read(8'h03, 24'h000100, 3, 1'b0, 0, "R10");
    for (int r = 0; r < 3; r++) begin
      logic [23:0] ra;
      ra = 24'($urandom);
      run_read(8'h03, ra, 2, 1'b0, 0, "");
    end
    // R4: upper address bits ignored
    run_read(8'h03, 24'hFC0123, 2, 1'b0, 0, "R4");
    // R7: wrap across the top of the array
    run_read(8'h03, 24'(DEPTH - 2), 4, 1'b0, 0, "");
    // R8: abort three bits into the second byte, then a clean read
    run_read(8'h03, 24'h000040, 1, 1'b0, 3, "");
    run_read(8'h03, 24'h000041, 2, 1'b0, 0, "R8");
    // R9: busy rejects the read
    run_read(8'h03, 24'h000200, 2, 1'b1, 0, "R9");
    // R3: unknown instruction keeps the output off
    run_read(8'h0B, 24'h000200, 2, 1'b0, 0, "R3");
    run_read(8'h03, 24'h000200, 2, 1'b0, 0, "");
    finish_run();
  end
endmodule